// File: doc/BRIEF.md
# Edge-Triggered Dead-Time Gate Controller

This block is the digital control for one leg of a half-bridge gate pre-driver. Two command inputs, one for the high-side switch and one for the low-side switch, act on their rising edges rather than on their levels. The most recent rising edge picks the switch that should conduct. The opposite gate is dropped on the same clock edge that samples the command. The chosen gate then waits until a programmable dead time has run out since the last turn-off.

Whenever either gate is switched off, the dead-time counter restarts. A turn-on request that arrives after the counter has already expired takes effect on the very next edge. After each enable, the high-side gate stays locked out until the low-side gate has conducted once, so that the bootstrap supply gets charged first. Each change on a command input opens a blanking window that masks the current-limit comparator. Three instances make up a three-phase driver.

Top module: `gate_dt_leg`

## Requirements
- R1: While `enable` is sampled low, and during reset, both gate outputs are 0 and `blanking` is 0 from the next clock edge on. The dead-time counter is cleared to the expired state, so the first request after enabling is not delayed.
- R2: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R3: A rising edge on one command input drives the opposite gate output to 0 on the clock edge that samples it.
- R4: Let D be the dead-time value. When a gate turns off and the opposite side is selected, the opposite gate turns on exactly D clock edges later, leaving D cycles with both gates off.
- R5: If the dead-time counter has expired, a rising edge on a command turns its gate on at the clock edge that samples it.
- R6: A falling edge on the command of the selected side turns that gate off at the sampling edge and leaves no side selected. Any gate turn-off restarts the dead time, which is measured from the turn-off and not from a later request. A falling edge on the command of the side that is not selected has no effect on the gates.
- R7: After each rise of `enable`, rising edges on `cmd_hi` are ignored until `gate_lo` has been 1 at least once. Disabling and enabling again brings the lockout back.
- R8: Rising edges on both commands in the same cycle count as a fault. Both gates go to 0 and stay there until a new single rising edge arrives.
- R9: A change of level on either command while enabled makes `blanking` 1 for exactly B cycles, starting at the sampling edge, where B is the blanking value. `ilim_trip` equals `ilim_sense` while `blanking` is 0 and is 0 while `blanking` is 1.
- R10: D is taken from `dead_cycles` and B from `blank_cycles` at the clock edge where `enable` is first sampled high. Later changes to these inputs have no effect until the next enable.
- R11: A command that is held high with no rising edge while enabled, including a level that was already high when `enable` rose, turns no gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Leg enable; low forces both gates off |
| cmd_hi | input | 1 | High-side command, rising-edge active |
| cmd_lo | input | 1 | Low-side command, rising-edge active |
| dead_cycles | input | CNT_W | Dead time in clock cycles, taken at enable |
| blank_cycles | input | CNT_W | Current-limit blanking length in cycles, taken at enable |
| ilim_sense | input | 1 | Raw current-limit comparator output |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| blanking | output | 1 | Current-limit blanking window active |
| ilim_trip | output | 1 | Current-limit fault, qualified by the blanking window |

## Verification
The bound checker watches, on every cycle, the properties that hold at any moment:
- the gates are mutually exclusive;
- disable forces both gates off;
- a rising edge on a command clears the opposite gate, and a falling edge clears the gate of its own side;
- a double rising edge leaves both gates off;
- the high gate never conducts before the low gate has been seen on since enable;
- every opening of the blanking window has an input change as its cause.

Some behaviours depend on the exact dead-time and blanking lengths, or on history. These are the exact D-cycle gap, immediate turn-on after the counter has expired, a restart measured from the turn-off, ignoring held levels, and holding the lengths fixed while the inputs change. Only the bench scenarios can show these, comparing gate and blanking values at chosen cycles.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_HI   = 2'd1,
      SEL_LO   = 2'd2
   } leg_sel_e;
endpackage

// File: rtl/gdt_edge_det.sv
module gdt_edge_det #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall,
   output logic         chg_any
);
   logic [N-1:0] prev_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q[i] <= 1'b0;
         else        prev_q[i] <= din[i];
      end
      assign rise[i] = din[i] & ~prev_q[i];
      assign fall[i] = ~din[i] & prev_q[i];
   end

   assign chg_any = |(din ^ prev_q);
endmodule

// File: rtl/gdt_cfg_hold.sv
module gdt_cfg_hold #(
   parameter int W = 8,
   parameter int N = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                open,
   input  logic [N-1:0][W-1:0] din,
   output logic [N-1:0][W-1:0] dout
);
   for (genvar f = 0; f < N; f++) begin : g_field
      logic [W-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    hold_q <= '0;
         else if (open) hold_q <= din[f];
      end
      assign dout[f] = open ? din[f] : hold_q;
   end
endmodule

// File: rtl/gdt_down_cnt.sv
module gdt_down_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         done_nxt
);
   logic [W-1:0] cnt_q, cnt_d;

   always_comb begin
      if (clr)             cnt_d = '0;
      else if (load)       cnt_d = val;
      else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
      else                 cnt_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign done_nxt = (cnt_d == '0);
endmodule

// File: rtl/gate_dt_leg.sv
module gate_dt_leg
   import gdt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cmd_hi,
   input  logic             cmd_lo,
   input  logic [CNT_W-1:0] dead_cycles,
   input  logic [CNT_W-1:0] blank_cycles,
   input  logic             ilim_sense,
   output logic             gate_hi,
   output logic             gate_lo,
   output logic             blanking,
   output logic             ilim_trip
);
   localparam int NCMD   = 2;
   localparam int IX_HI  = 0;
   localparam int IX_LO  = 1;
   localparam int NCFG   = 2;
   localparam int IX_DT  = 0;
   localparam int IX_BL  = 1;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("gate_dt_leg: CNT_W must lie in 2..16");
   end

   logic en_q;
   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= enable;
   end

   // configuration: follows the inputs until enable is first sampled
   logic [NCFG-1:0][CNT_W-1:0] cfg_in, cfg_eff;
   assign cfg_in[IX_DT] = dead_cycles;
   assign cfg_in[IX_BL] = blank_cycles;

   gdt_cfg_hold #(.W(CNT_W), .N(NCFG)) u_cfg (
      .clk(clk), .rst_n(rst_n), .open(!en_q), .din(cfg_in), .dout(cfg_eff)
   );

   // command edges
   logic [NCMD-1:0] cmd_v, rise, fall;
   logic            chg_any;
   assign cmd_v[IX_HI] = cmd_hi;
   assign cmd_v[IX_LO] = cmd_lo;

   gdt_edge_det #(.N(NCMD)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(cmd_v),
      .rise(rise), .fall(fall), .chg_any(chg_any)
   );

   // selection state
   leg_sel_e sel_q, sel_d;
   logic     armed_q, armed_d;
   logic     hi_q, lo_q, hi_d, lo_d;
   logic     off_evt, dt_done_nxt, bl_done_nxt, blank_q;

   always_comb begin
      sel_d = sel_q;
      if (!enable)                       sel_d = SEL_NONE;
      else if (rise[IX_HI] && rise[IX_LO]) sel_d = SEL_NONE;
      else if (rise[IX_HI]) begin
         if (armed_q)                    sel_d = SEL_HI;
      end
      else if (rise[IX_LO])              sel_d = SEL_LO;
      else if (fall[IX_HI] && sel_q == SEL_HI) sel_d = SEL_NONE;
      else if (fall[IX_LO] && sel_q == SEL_LO) sel_d = SEL_NONE;
   end

   assign off_evt = enable &&
                    ((hi_q && sel_d != SEL_HI) || (lo_q && sel_d != SEL_LO));

   gdt_down_cnt #(.W(CNT_W)) u_dead (
      .clk(clk), .rst_n(rst_n), .clr(!enable), .load(off_evt),
      .val(cfg_eff[IX_DT]), .done_nxt(dt_done_nxt)
   );

   assign hi_d    = enable && sel_d == SEL_HI && (hi_q || dt_done_nxt);
   assign lo_d    = enable && sel_d == SEL_LO && (lo_q || dt_done_nxt);
   assign armed_d = enable && (armed_q || lo_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= SEL_NONE;
         armed_q <= 1'b0;
         hi_q    <= 1'b0;
         lo_q    <= 1'b0;
      end else begin
         sel_q   <= sel_d;
         armed_q <= armed_d;
         hi_q    <= hi_d;
         lo_q    <= lo_d;
      end
   end

   // current-limit blanking
   gdt_down_cnt #(.W(CNT_W)) u_blank (
      .clk(clk), .rst_n(rst_n), .clr(!enable), .load(enable && chg_any),
      .val(cfg_eff[IX_BL]), .done_nxt(bl_done_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) blank_q <= 1'b0;
      else        blank_q <= !bl_done_nxt;
   end

   assign gate_hi   = hi_q;
   assign gate_lo   = lo_q;
   assign blanking  = blank_q;
   assign ilim_trip = ilim_sense && !blank_q;
endmodule

// File: rtl/gdt_leg_chk.sv
module gdt_leg_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic cmd_hi,
   input logic cmd_lo,
   input logic gate_hi,
   input logic gate_lo,
   input logic blanking
);
   logic p_hi, p_lo, lo_seen, chg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_hi    <= 1'b0;
         p_lo    <= 1'b0;
         lo_seen <= 1'b0;
         chg_q   <= 1'b0;
      end else begin
         p_hi    <= cmd_hi;
         p_lo    <= cmd_lo;
         lo_seen <= enable && (lo_seen || gate_lo);
         chg_q   <= enable && ((cmd_hi ^ p_hi) || (cmd_lo ^ p_lo));
      end
   end

   assert_off_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!gate_hi && !gate_lo && !blanking));

   assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   assert_lo_edge_drops_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cmd_lo && !p_lo) |=> !gate_hi);

   assert_hi_edge_drops_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cmd_hi && !p_hi) |=> !gate_lo);

   assert_lo_on_needs_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> p_lo);

   assert_fall_drops_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !cmd_hi && p_hi) |=> !gate_hi);

   assert_hi_after_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gate_hi |-> lo_seen);

   assert_double_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cmd_hi && !p_hi && cmd_lo && !p_lo) |=> (!gate_hi && !gate_lo));

   assert_blank_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blanking) |-> chg_q);
endmodule

bind gate_dt_leg gdt_leg_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
   .gate_hi(gate_hi), .gate_lo(gate_lo), .blanking(blanking)
);

// File: tb/tb_gate_dt_leg.sv
`timescale 1ns/100ps
module tb_gate_dt_leg;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n, enable, cmd_hi, cmd_lo, ilim_sense;
   logic [CNT_W-1:0] dead_cycles, blank_cycles;
   logic gate_hi, gate_lo, blanking, ilim_trip;

   gate_dt_leg #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
      .dead_cycles(dead_cycles), .blank_cycles(blank_cycles), .ilim_sense(ilim_sense),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .blanking(blanking), .ilim_trip(ilim_trip)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      int    cyc;
      bit    h;
      bit    l;
      bit    chk_b;
      bit    b;
      bit    t;
      string req;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic put(int d, bit h, bit l, bit cb, bit b, bit t, string r);
      exp_t e;
      e.cyc = cyc + d; e.h = h; e.l = l; e.chk_b = cb; e.b = b; e.t = t; e.req = r;
      q.push_back(e);
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pop items due this cycle and compare
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         n_chk++;
         if (gate_hi && gate_lo) begin
            n_bad++;
            $display("FAIL R2 cyc %0d: gates hi=%0b lo=%0b, expected not both 1", cyc, gate_hi, gate_lo);
         end
      end
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].cyc == cyc) begin
            n_chk++;
            if (gate_hi !== q[i].h || gate_lo !== q[i].l || ilim_trip !== q[i].t ||
                (q[i].chk_b && blanking !== q[i].b)) begin
               n_bad++;
               $display("FAIL %s cyc %0d: hi/lo/blank/trip actual %0b%0b%0b%0b expected %0b%0b%0b%0b",
                        q[i].req, cyc, gate_hi, gate_lo, blanking, ilim_trip,
                        q[i].h, q[i].l, q[i].chk_b ? q[i].b : blanking, q[i].t);
            end
            q.delete(i);
         end
      end
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; cmd_hi = 1'b0; cmd_lo = 1'b0; ilim_sense = 1'b0;
      dead_cycles = 8'd4; blank_cycles = 8'd3;
      wait_n(4);
      rst_n = 1'b1;
      put(1, 0, 0, 1, 0, 0, "R1"); put(3, 0, 0, 1, 0, 0, "R1");
      wait_n(4);
      cmd_hi = 1'b1;                                  // level while disabled
      put(1, 0, 0, 1, 0, 0, "R1");
      wait_n(3);
      enable = 1'b1;                                  // D=4, B=3 captured
      for (int d = 1; d <= 6; d++) put(d, 0, 0, 1, 0, 0, "R11");
      wait_n(1);
      dead_cycles = 8'd9; blank_cycles = 8'd9;        // must be ignored (R10)
      wait_n(6);
      cmd_hi = 1'b0;                                  // change -> 3-cycle window
      put(1, 0, 0, 1, 1, 0, "R9"); put(3, 0, 0, 1, 1, 0, "R9");
      put(4, 0, 0, 1, 0, 0, "R10");
      wait_n(6);
      cmd_lo = 1'b1;                                  // expired timer -> at once
      put(1, 0, 1, 1, 1, 0, "R5");
      wait_n(6);
      cmd_hi = 1'b1;                                  // swap with dead time 4
      put(1, 0, 0, 0, 0, 0, "R3"); put(4, 0, 0, 0, 0, 0, "R4");
      put(5, 1, 0, 0, 0, 0, "R4");
      wait_n(8);
      cmd_hi = 1'b0;                                  // falling edge of selected
      put(1, 0, 0, 0, 0, 0, "R6");
      wait_n(1);
      cmd_lo = 1'b0;
      wait_n(1);
      cmd_lo = 1'b1;                                  // timer runs from turn-off
      put(2, 0, 0, 0, 0, 0, "R6"); put(3, 0, 1, 0, 0, 0, "R6");
      wait_n(6);
      cmd_lo = 1'b0;
      put(1, 0, 0, 0, 0, 0, "R6");
      wait_n(10);
      cmd_hi = 1'b1;                                  // armed, timer expired
      put(1, 1, 0, 0, 0, 0, "R5");
      wait_n(4);
      cmd_hi = 1'b0;
      put(1, 0, 0, 0, 0, 0, "R6");
      wait_n(8);
      cmd_hi = 1'b1; cmd_lo = 1'b1;                   // double edge fault
      for (int d = 1; d <= 7; d++) put(d, 0, 0, 0, 0, 0, "R8");
      wait_n(8);
      enable = 1'b0;
      put(1, 0, 0, 1, 0, 0, "R1");
      wait_n(1);
      cmd_hi = 1'b0; cmd_lo = 1'b0; dead_cycles = 8'd2; blank_cycles = 8'd2;
      wait_n(3);
      enable = 1'b1;                                  // D=2, B=2 captured
      wait_n(2);
      cmd_hi = 1'b1;                                  // lockout again
      for (int d = 1; d <= 6; d++) put(d, 0, 0, 0, 0, 0, "R7");
      wait_n(7);
      cmd_lo = 1'b1;
      put(1, 0, 1, 0, 0, 0, "R7");
      wait_n(4);
      cmd_hi = 1'b0;                                  // fall of unselected side
      put(1, 0, 1, 0, 0, 0, "R6");
      wait_n(6);
      cmd_hi = 1'b1;                                  // swap with new D=2
      put(1, 0, 0, 0, 0, 0, "R3"); put(2, 0, 0, 0, 0, 0, "R10");
      put(3, 1, 0, 0, 0, 0, "R10");
      wait_n(8);
      ilim_sense = 1'b1; cmd_lo = 1'b0;               // masked for B=2 cycles
      put(1, 1, 0, 1, 1, 0, "R9"); put(2, 1, 0, 1, 1, 0, "R9");
      put(3, 1, 0, 1, 0, 1, "R9");
      wait_n(5);
      ilim_sense = 1'b0;
      wait_n(3);
      while (q.size() > 0) begin
         n_chk++; n_bad++;
         $display("FAIL %s: item for cyc %0d never compared (actual none, expected compare)",
                  q[0].req, q[0].cyc);
         void'(q.pop_front());
      end
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule